// File: doc/BRIEF.md
# Configuration Address/Data Window Bridge

The bridge sits between a processor's register bus and the configuration request path of a peripheral interconnect. Software sees two windows. The address window holds a 32-bit selector that names a bus, a device/function and a register offset, with an enable bit at the top. The data window turns each processor access into one configuration request on the downstream interface, provided the enable bit is set.

When a request is issued, the bridge places the bus, device/function, merged register offset, clamped length and right-justified write data on the downstream interface. It then waits for a single response that reports whether the target exists, whether it is enabled, whether it was hot-added, and whether function 0 of the same device exists. From that response the bridge decides by itself whether a write is committed and whether a read returns target data or all-ones. The processor sees completion as a one-cycle `hostDone` pulse. Read data stays on `hostRdata` until the next read completes.

Top module: `cfg_window_bridge`

## Requirements
- R1: After reset the selector register is zero, `hostReady` is 1, and `reqValid`, `hostDone` and `wrCommit` are 0. A data-window read issued straight after reset returns 0xFFFFFFFF.
- R2: A write to the address window (`hostSel`=0) updates the selector only when `hostOffset`=0 and `hostLen`=4. Any other write to that window leaves the selector unchanged.
- R3: A read of the address window returns the stored selector for every offset and length. It completes with `hostDone` one cycle after acceptance.
- R4: When selector bit 31 is 0, a data-window (`hostSel`=1) read returns 0xFFFFFFFF and a data-window write completes without raising `reqValid` or `wrCommit`.
- R5: A request carries `reqBus` = selector[23:16] and `reqDevFn` = selector[15:8], where the device is in bits 7:3 of `reqDevFn` and the function is in bits 2:0. It also carries `reqReg` = selector[7:0] bitwise-ORed with the 2-bit access offset.
- R6: `hostLen` values 1 to 4 are used as given, and 0 or values above 4 are treated as 4. `reqLen` is that value clamped to 256 minus `reqReg`.
- R7: If the response reports the target as absent or disabled, a read returns 0xFFFFFFFF and a write gets no `wrCommit`.
- R8: A hot-added target whose function number is nonzero is treated as absent when the response reports function 0 missing. Function 0 itself, or a target that was not hot-added, is not affected by this rule.
- R9: Accepted read data is shifted left by 8 times `reqReg`[1:0] onto the little-endian lanes. `reqWdata` is `hostWdata` shifted right by 8 times the access offset.
- R10: `reqValid` is a one-cycle pulse, raised one cycle after a data access is accepted. `hostReady` stays 0 from then until the response arrives, so at most one request is outstanding.
- R11: A data access that issues a request completes with `hostDone` (and `wrCommit` for an accepted write) one cycle after the cycle in which `rspValid` is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hostValid | input | 1 | Processor access strobe, accepted when hostReady is 1 |
| hostReady | output | 1 | Bridge idle and able to take an access |
| hostSel | input | 1 | 0 = address window, 1 = data window |
| hostWrite | input | 1 | 1 = write, 0 = read |
| hostOffset | input | 2 | Byte offset inside the window |
| hostLen | input | 3 | Access length in bytes |
| hostWdata | input | 32 | Processor write data, lane-aligned |
| hostDone | output | 1 | One-cycle completion pulse |
| hostRdata | output | 32 | Read result, held until the next read completes |
| reqValid | output | 1 | One-cycle configuration request pulse |
| reqWrite | output | 1 | Request is a write |
| reqBus | output | 8 | Target bus number |
| reqDevFn | output | 8 | Target device (7:3) and function (2:0) |
| reqReg | output | 8 | Register offset in configuration space |
| reqLen | output | 3 | Clamped length in bytes |
| reqWdata | output | 32 | Right-justified write data |
| wrCommit | output | 1 | Pulse: the pending write is accepted by the target |
| rspValid | input | 1 | Response strobe for the outstanding request |
| rspPresent | input | 1 | Target exists |
| rspEnabled | input | 1 | Target is enabled |
| rspHotAdded | input | 1 | Target was hot-added |
| rspFn0Present | input | 1 | Function 0 of the same device exists |
| rspRdata | input | 32 | Right-justified read data from the target |

## Verification
A corrupted selector shows at the next address-window read. It also shows at the next data access, where the request fields or enable gating come out wrong in the cycle `reqValid` rises. A controller stuck in its waiting state holds `hostReady` low past the response cycle, and the per-cycle comparison catches this one clock later. A wrong acceptance decision shows as a missing or extra `wrCommit`, or as all-ones in place of target data, in the single `hostDone` cycle after the response.

// File: rtl/cfg_window_pkg.sv
package cfg_window_pkg;
  localparam int DATA_W    = 32;
  localparam int REG_W     = 8;
  localparam int LEN_W     = 3;
  localparam int MAX_LEN   = 4;
  localparam int CFG_BYTES = 1 << REG_W;

  typedef enum logic [1:0] {
    RD_KEEP = 2'd0,
    RD_CFG  = 2'd1,
    RD_ONES = 2'd2,
    RD_TGT  = 2'd3
  } rdSrc_e;

  typedef struct packed {
    logic   loadCfg;
    logic   latchReq;
    logic   issueReq;
    logic   finish;
    logic   commit;
    rdSrc_e rdSrc;
  } ctlStrobes_t;
endpackage

// File: rtl/cfg_window_dp.sv
module cfg_window_dp
  import cfg_window_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  ctlStrobes_t         st,
  input  logic                hostWrite,
  input  logic [1:0]          hostOffset,
  input  logic [LEN_W-1:0]    hostLen,
  input  logic [DATA_W-1:0]   hostWdata,
  input  logic [DATA_W-1:0]   rspRdata,
  output logic [DATA_W-1:0]   cfgWord,
  output logic                pendWrite,
  output logic                fnNonZero,
  output logic                hostDone,
  output logic [DATA_W-1:0]   hostRdata,
  output logic                reqValid,
  output logic                reqWrite,
  output logic [7:0]          reqBus,
  output logic [7:0]          reqDevFn,
  output logic [REG_W-1:0]    reqReg,
  output logic [LEN_W-1:0]    reqLen,
  output logic [DATA_W-1:0]   reqWdata,
  output logic                wrCommit
);
  localparam int ROOM_W = REG_W + 1;

  logic [DATA_W-1:0] cfgReg;
  logic [REG_W-1:0]  regNext;
  logic [LEN_W-1:0]  lenNorm;
  logic [ROOM_W-1:0] room;
  logic [LEN_W-1:0]  lenClamp;

  always_comb begin
    regNext  = cfgReg[REG_W-1:0] | {{(REG_W-2){1'b0}}, hostOffset};
    lenNorm  = (hostLen == '0 || hostLen > LEN_W'(MAX_LEN)) ? LEN_W'(MAX_LEN) : hostLen;
    room     = ROOM_W'(CFG_BYTES) - {1'b0, regNext};
    lenClamp = ({{(ROOM_W-LEN_W){1'b0}}, lenNorm} > room) ? room[LEN_W-1:0] : lenNorm;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfgReg    <= '0;
      reqValid  <= 1'b0;
      hostDone  <= 1'b0;
      wrCommit  <= 1'b0;
      hostRdata <= '0;
      reqWrite  <= 1'b0;
      reqBus    <= '0;
      reqDevFn  <= '0;
      reqReg    <= '0;
      reqLen    <= '0;
      reqWdata  <= '0;
    end else begin
      if (st.loadCfg) cfgReg <= hostWdata;
      if (st.latchReq) begin
        reqWrite <= hostWrite;
        reqBus   <= cfgReg[23:16];
        reqDevFn <= cfgReg[15:8];
        reqReg   <= regNext;
        reqLen   <= lenClamp;
        reqWdata <= hostWdata >> {hostOffset, 3'b000};
      end
      reqValid <= st.issueReq;
      hostDone <= st.finish;
      wrCommit <= st.commit;
      case (st.rdSrc)
        RD_CFG:  hostRdata <= cfgReg;
        RD_ONES: hostRdata <= '1;
        RD_TGT:  hostRdata <= rspRdata << {reqReg[1:0], 3'b000};
        default: ;
      endcase
    end
  end

  assign cfgWord   = cfgReg;
  assign pendWrite = reqWrite;
  assign fnNonZero = (reqDevFn[2:0] != 3'd0);

  // R10: request strobe never lasts two cycles
  p_req_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    reqValid |=> !reqValid);
  // R6: issued length stays within 1..4 and inside configuration space
  p_len_bound_r6: assert property (@(posedge clk) disable iff (rst)
    reqValid |-> (reqLen != '0 && reqLen <= LEN_W'(MAX_LEN) &&
                  ({1'b0, reqReg} + {{(ROOM_W-LEN_W){1'b0}}, reqLen}) <= ROOM_W'(CFG_BYTES)));
  // R7: a write acceptance is only signalled together with completion
  p_commit_done_r7: assert property (@(posedge clk) disable iff (rst)
    wrCommit |-> (hostDone && reqWrite));
endmodule

// File: rtl/cfg_window_ctrl.sv
module cfg_window_ctrl
  import cfg_window_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             hostValid,
  input  logic             hostSel,
  input  logic             hostWrite,
  input  logic [1:0]       hostOffset,
  input  logic [LEN_W-1:0] hostLen,
  input  logic             cfgEn,
  input  logic             pendWrite,
  input  logic             fnNonZero,
  input  logic             rspValid,
  input  logic             rspPresent,
  input  logic             rspEnabled,
  input  logic             rspHotAdded,
  input  logic             rspFn0Present,
  output logic             hostReady,
  output ctlStrobes_t      st
);
  typedef enum logic {S_IDLE, S_WAIT} state_e;
  state_e state, stateNext;
  logic   accept;

  always_comb begin
    accept    = rspPresent && rspEnabled && !(rspHotAdded && fnNonZero && !rspFn0Present);
    st        = '0;
    stateNext = state;
    case (state)
      S_IDLE: if (hostValid) begin
        if (!hostSel) begin
          st.loadCfg = hostWrite && hostOffset == 2'd0 && hostLen == LEN_W'(MAX_LEN);
          st.rdSrc   = hostWrite ? RD_KEEP : RD_CFG;
          st.finish  = 1'b1;
        end else if (!cfgEn) begin
          st.rdSrc   = hostWrite ? RD_KEEP : RD_ONES;
          st.finish  = 1'b1;
        end else begin
          st.latchReq = 1'b1;
          st.issueReq = 1'b1;
          stateNext   = S_WAIT;
        end
      end
      S_WAIT: if (rspValid) begin
        st.finish = 1'b1;
        st.commit = pendWrite && accept;
        st.rdSrc  = pendWrite ? RD_KEEP : (accept ? RD_TGT : RD_ONES);
        stateNext = S_IDLE;
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= S_IDLE;
    else     state <= stateNext;
  end

  assign hostReady = (state == S_IDLE);

  // R10: a request is only launched from the idle state
  p_issue_idle_r10: assert property (@(posedge clk) disable iff (rst)
    st.issueReq |=> (state == S_WAIT));
  // R4: nothing is launched while the selector enable is clear
  p_gate_enable_r4: assert property (@(posedge clk) disable iff (rst)
    st.issueReq |-> cfgEn);
endmodule

// File: rtl/cfg_window_bridge.sv
module cfg_window_bridge
  import cfg_window_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        hostValid,
  output logic        hostReady,
  input  logic        hostSel,
  input  logic        hostWrite,
  input  logic [1:0]  hostOffset,
  input  logic [2:0]  hostLen,
  input  logic [31:0] hostWdata,
  output logic        hostDone,
  output logic [31:0] hostRdata,
  output logic        reqValid,
  output logic        reqWrite,
  output logic [7:0]  reqBus,
  output logic [7:0]  reqDevFn,
  output logic [7:0]  reqReg,
  output logic [2:0]  reqLen,
  output logic [31:0] reqWdata,
  output logic        wrCommit,
  input  logic        rspValid,
  input  logic        rspPresent,
  input  logic        rspEnabled,
  input  logic        rspHotAdded,
  input  logic        rspFn0Present,
  input  logic [31:0] rspRdata
);
  ctlStrobes_t st;
  logic [DATA_W-1:0] cfgWord;
  logic pendWrite, fnNonZero;

  cfg_window_ctrl u_ctrl (
    .clk(clk), .rst(rst), .hostValid(hostValid), .hostSel(hostSel),
    .hostWrite(hostWrite), .hostOffset(hostOffset), .hostLen(hostLen),
    .cfgEn(cfgWord[31]), .pendWrite(pendWrite), .fnNonZero(fnNonZero),
    .rspValid(rspValid), .rspPresent(rspPresent), .rspEnabled(rspEnabled),
    .rspHotAdded(rspHotAdded), .rspFn0Present(rspFn0Present),
    .hostReady(hostReady), .st(st)
  );

  cfg_window_dp u_dp (
    .clk(clk), .rst(rst), .st(st), .hostWrite(hostWrite),
    .hostOffset(hostOffset), .hostLen(hostLen), .hostWdata(hostWdata),
    .rspRdata(rspRdata), .cfgWord(cfgWord), .pendWrite(pendWrite),
    .fnNonZero(fnNonZero), .hostDone(hostDone), .hostRdata(hostRdata),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqBus(reqBus),
    .reqDevFn(reqDevFn), .reqReg(reqReg), .reqLen(reqLen),
    .reqWdata(reqWdata), .wrCommit(wrCommit)
  );

  // R2: selector only changes after a full-width write at offset 0 of the address window
  p_cfg_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !(hostValid && hostReady && !hostSel && hostWrite && hostOffset == 2'd0 && hostLen == 3'd4)
    |=> $stable(cfgWord));
  // R10: no new access is taken while a request is in flight
  p_ready_low_r10: assert property (@(posedge clk) disable iff (rst)
    reqValid |-> !hostReady);
endmodule

// File: tb/test_cfg_window_bridge.sv
module test_cfg_window_bridge;
  logic clk = 1'b0, rst = 1'b1;
  logic hostValid = 0, hostSel = 0, hostWrite = 0;
  logic [1:0] hostOffset = 0;
  logic [2:0] hostLen = 0;
  logic [31:0] hostWdata = 0, rspRdata = 0;
  logic rspValid = 0, rspPresent = 0, rspEnabled = 0, rspHotAdded = 0, rspFn0Present = 0;
  logic hostReady, hostDone, reqValid, reqWrite, wrCommit;
  logic [31:0] hostRdata, reqWdata;
  logic [7:0] reqBus, reqDevFn, reqReg;
  logic [2:0] reqLen;

  int vectors = 0, fails = 0, cycles = 0;
  // response the bench-side target will give
  bit tPres, tEn, tHot, tFn0;
  logic [31:0] tData;

  always #10 clk = ~clk;

  cfg_window_bridge i_cfg_window_bridge (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int mState = 0;
  logic [31:0] mCfg = 0, mRd = 0, mWd = 0;
  bit mDone = 0, mReq = 0, mCommit = 0, mWr = 0;
  int mBus = 0, mDevFn = 0, mReg = 0, mLen = 0;
  string rdTag = "R1";

  always @(posedge clk) begin
    if (rst) begin
      mState = 0; mCfg = 0; mRd = 0; mDone = 0; mReq = 0; mCommit = 0;
    end else begin
      mDone = 0; mReq = 0; mCommit = 0;
      if (mState == 0 && hostValid) begin
        if (!hostSel) begin
          if (hostWrite && hostOffset == 0 && hostLen == 4) mCfg = hostWdata;
          if (!hostWrite) begin mRd = mCfg; rdTag = "R3"; end
          mDone = 1;
        end else if (!mCfg[31]) begin
          if (!hostWrite) begin mRd = 32'hFFFF_FFFF; rdTag = "R4"; end
          mDone = 1;
        end else begin
          int ln;
          mBus = int'(mCfg[23:16]); mDevFn = int'(mCfg[15:8]);
          mReg = int'(mCfg[7:0]) | int'(hostOffset);
          ln = (hostLen == 0 || hostLen > 4) ? 4 : int'(hostLen);
          mLen = (ln > 256 - mReg) ? 256 - mReg : ln;
          mWr = hostWrite; mWd = hostWdata >> (8 * int'(hostOffset));
          mReq = 1; mState = 1;
        end
      end else if (mState == 1 && rspValid) begin
        bit hidden, ok;
        hidden = rspHotAdded && (mDevFn % 8 != 0) && !rspFn0Present;
        ok = rspPresent && rspEnabled && !hidden;
        rdTag = ok ? "R9" : (hidden ? "R8" : "R7");
        mDone = 1;
        if (mWr) mCommit = ok;
        else mRd = ok ? (rspRdata << (8 * (mReg % 4))) : 32'hFFFF_FFFF;
        mState = 0;
      end
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      chk("R10 hostReady", 32'(hostReady), 32'(mState == 0));
      chk("R10 reqValid", 32'(reqValid), 32'(mReq));
      chk("R11 hostDone", 32'(hostDone), 32'(mDone));
      chk({rdTag, " wrCommit"}, 32'(wrCommit), 32'(mCommit));
      chk({rdTag, " hostRdata"}, hostRdata, mRd);
      if (mReq) begin
        chk("R5 reqBus", 32'(reqBus), 32'(mBus));
        chk("R5 reqDevFn", 32'(reqDevFn), 32'(mDevFn));
        chk("R5 reqReg", 32'(reqReg), 32'(mReg));
        chk("R6 reqLen", 32'(reqLen), 32'(mLen));
        chk("R9 reqWdata", reqWdata, mWd);
        chk("R10 reqWrite", 32'(reqWrite), 32'(mWr));
      end
    end
  end

  // target responder: answers two cycles after each request
  initial begin
    forever begin
      @(negedge clk);
      if (reqValid) begin
        @(negedge clk);
        @(negedge clk);
        rspValid = 1; rspPresent = tPres; rspEnabled = tEn;
        rspHotAdded = tHot; rspFn0Present = tFn0; rspRdata = tData;
        @(negedge clk);
        rspValid = 0; rspRdata = 32'h5A5A_5A5A;
      end
    end
  end

  task automatic access(bit sel, bit wr, logic [1:0] off, logic [2:0] len, logic [31:0] wd);
    @(negedge clk);
    while (!hostReady) @(negedge clk);
    hostValid = 1; hostSel = sel; hostWrite = wr; hostOffset = off; hostLen = len; hostWdata = wd;
    @(negedge clk);
    hostValid = 0;
    while (!hostDone) @(negedge clk);
  endtask

  task automatic target(bit p, bit e, bit h, bit f0, logic [31:0] d);
    tPres = p; tEn = e; tHot = h; tFn0 = f0; tData = d;
  endtask

  initial begin
    target(1, 1, 0, 1, 0);
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 reset hostReady", 32'(hostReady), 1);
    chk("R1 reset reqValid", 32'(reqValid), 0);
    chk("R1 reset hostDone", 32'(hostDone), 0);
    access(1, 0, 0, 4, 0);
    chk("R1 data read after reset", hostRdata, 32'hFFFF_FFFF);
    access(1, 1, 0, 4, 32'h1234_5678);          // R4 disabled write
    access(0, 1, 1, 4, 32'h8000_0000);          // R2 wrong offset
    access(0, 1, 0, 2, 32'h8000_0000);          // R2 wrong length
    access(0, 0, 2, 1, 0);
    chk("R2 selector unchanged", hostRdata, 32'h0);
    access(0, 1, 0, 4, 32'h8012_3A40);
    access(0, 0, 3, 2, 0);
    chk("R3 selector readback", hostRdata, 32'h8012_3A40);
    target(1, 1, 0, 1, 32'h1122_3344);
    access(1, 0, 0, 4, 0);
    chk("R9 aligned read", hostRdata, 32'h1122_3344);
    target(1, 1, 0, 1, 32'h0000_BEEF);
    access(1, 0, 2, 2, 0);
    chk("R9 lane shift", hostRdata, 32'hBEEF_0000);
    access(1, 1, 1, 1, 32'h0000_AB00);          // R9 write right-justify, commit
    target(0, 1, 0, 1, 32'h0BAD_0BAD);
    access(1, 0, 0, 4, 0);
    chk("R7 absent read", hostRdata, 32'hFFFF_FFFF);
    access(1, 1, 0, 4, 32'hCAFE_F00D);          // R7 absent write dropped
    target(1, 0, 0, 1, 32'h0BAD_0BAD);
    access(1, 0, 0, 4, 0);
    chk("R7 disabled read", hostRdata, 32'hFFFF_FFFF);
    target(1, 1, 1, 0, 32'h7777_7777);
    access(1, 0, 0, 4, 0);
    chk("R8 hidden function", hostRdata, 32'hFFFF_FFFF);
    access(1, 1, 0, 4, 32'h1);                  // R8 hidden write dropped
    target(1, 1, 1, 1, 32'h7777_7777);
    access(1, 0, 0, 4, 0);
    chk("R8 function 0 present", hostRdata, 32'h7777_7777);
    access(0, 1, 0, 4, 32'h8012_3841);          // function 0, reg 0x41
    target(1, 1, 1, 0, 32'h0000_0066);
    access(1, 0, 2, 1, 0);                      // reg 0x43
    chk("R8 function 0 never hidden", hostRdata, 32'h6600_0000);
    access(0, 1, 0, 4, 32'h8000_00FC);
    target(1, 1, 0, 1, 32'h0000_0099);
    access(1, 0, 3, 4, 0);                      // R6 clamp to 1 at 0xFF
    chk("R6 clamp read", hostRdata, 32'h9900_0000);
    access(0, 1, 0, 4, 32'h8000_0010);
    access(1, 1, 0, 7, 32'hDEAD_BEEF);          // R6 length 7 -> 4
    access(1, 0, 1, 0, 0);                      // R6 length 0 -> 4
    repeat (4) @(negedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=<20000 cycles", cycles);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule